// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

The block turns a 64-bit input address into an output address by reading descriptors from a hierarchy of translation tables in memory. A single start pulse supplies the input address, the table base register, the table-size offset and the number of address bits each level resolves. The walker then performs one 64-bit descriptor read per level over a request/response memory port, with at most one read outstanding at a time.

Each descriptor is either invalid, a pointer to the next table, or a leaf that maps a block or page. A walk ends with a one-cycle done pulse. At that point the block presents either the output address and page size, or a fault code. One translation stage is handled, and no results are cached between walks. Fault code values follow a shared code set: 0x01 is an external abort during the walk, 0x10 is a translation fault, and 0x11, 0x12, 0x13 and 0x20 are reserved for address-size, access, permission and conflict faults. This block never produces the reserved codes.

Top module: `ptw_walker`

## Requirements
- R1: The starting level is 4 - q. Here q is floor((60 - tsz_i) / idx_bits_i), capped at 4 and taken as 0 when tsz_i > 60. A result of level 4 is treated as level 3. With idx_bits_i = 9, tsz_i = 25 starts at level 1 and tsz_i = 16 starts at level 0.
- R2: The first table address is ttb_i[47:0] with bits below position 64 - tsz_i - idx_bits_i*(4 - start level) cleared.
- R3: The descriptor address at level L is (table | ((va_i >> idx_bits_i*(4-L)) & (2^(idx_bits_i+3) - 1))) with bits [2:0] cleared. mem_req_o is a one-cycle pulse per read. No new request is issued before the response to the previous one arrives.
- R4: A response with mem_rsp_err_i = 1 ends the walk with fault_o = 0x01.
- R5: A descriptor with bit 0 clear, or with bit 1 clear at level 3, ends the walk with fault_o = 0x10.
- R6: A descriptor with bits 1:0 = 2'b11 at a level below 3 gives the next table address as descriptor & 0xFFF_FFFF_F000, and the walk continues at the next level.
- R7: Any other valid descriptor is a leaf. page_size_o = 2^(idx_bits_i*(4 - L) + 3), and out_addr_o = (descriptor & 0xFFF_FFFF_F000) | (va_i & (page_size_o - 1)). fault_o = 0x00 on success.
- R8: busy_o rises the cycle after an accepted start and falls when done_o pulses. done_o is high for exactly one cycle.
- R9: out_addr_o, page_size_o and fault_o change only together with done_o. A start_i asserted while busy_o is high is ignored and does not alter the walk in progress.
- R10: The only fault values produced are 0x00, 0x01 and 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (accepted only when idle) |
| va_i | input | 64 | Input address to translate |
| ttb_i | input | 64 | Table base register |
| tsz_i | input | 6 | Table-size offset |
| idx_bits_i | input | 4 | Address bits resolved per level |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Descriptor read request pulse |
| mem_addr_o | output | 64 | Descriptor read address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 64 | Read response data, little-endian descriptor |
| mem_rsp_err_i | input | 1 | Read response error |
| out_addr_o | output | 64 | Translated output address |
| page_size_o | output | 64 | Size in bytes of the mapped page or block |
| fault_o | output | 8 | Fault code, 0x00 on success |

## Verification
The hardest case to reach is an error that arrives after one good table read. In that case the abort must replace a partially built walk rather than the first access. The behavioural memory marks one specific second-level descriptor address as failing, so only a walk that has already followed a valid level-1 table pointer reaches it. The start pulse ignored while busy is just as timing dependent. The bench raises start with different inputs while the walk waits on a response, then checks both the number of reads and the final output against the original walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W = 64;
  localparam int BASE_W = 48;
  localparam int LVL_W  = 2;
  localparam int MAX_LVL = 3;
  localparam logic [ADDR_W-1:0] OA_MASK = 64'h0000_0FFF_FFFF_F000;

  localparam logic [7:0] FLT_NONE       = 8'h00;
  localparam logic [7:0] FLT_WALK_ABORT = 8'h01;
  localparam logic [7:0] FLT_XLATE      = 8'h10;
  localparam logic [7:0] FLT_ADDR_SIZE  = 8'h11;
  localparam logic [7:0] FLT_ACCESS     = 8'h12;
  localparam logic [7:0] FLT_PERM       = 8'h13;
  localparam logic [7:0] FLT_CONFLICT   = 8'h20;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_state_e;
  typedef enum logic [1:0] {DK_INVALID, DK_TABLE, DK_LEAF} desc_kind_e;
endpackage

// File: rtl/ptw_start_calc.sv
module ptw_start_calc
  import ptw_pkg::*;
#(
  parameter int TSZ_W = 6,
  parameter int IDX_W = 4
) (
  input  logic [ADDR_W-1:0] ttb_i,
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic [IDX_W-1:0]  idx_bits_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int SPAN = ADDR_W - 4;

  int rem, q, lvl, sh;

  always_comb begin
    rem = SPAN - int'(tsz_i);
    if (rem < 0) rem = 0;
    q = 0;
    // repeated subtraction replaces a divider; quotient capped at 4
    for (int k = 0; k < 4; k++) begin
      if (rem >= int'(idx_bits_i)) begin
        rem = rem - int'(idx_bits_i);
        q   = q + 1;
      end
    end
    lvl = 4 - q;
    if (lvl > MAX_LVL) lvl = MAX_LVL;
    lvl_o = LVL_W'(lvl);
    sh = ADDR_W - int'(tsz_i) - int'(idx_bits_i) * (4 - lvl);
    base_o = {{(ADDR_W-BASE_W){1'b0}}, ttb_i[BASE_W-1:0]};
    if (sh >= ADDR_W) base_o = '0;
    else if (sh > 0) base_o = base_o & ~((64'd1 << sh) - 64'd1);
  end
endmodule

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr
  import ptw_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [ADDR_W-1:0] tbl_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [IDX_W-1:0]  idx_bits_i,
  output logic [ADDR_W-1:0] addr_o
);
  int sh, mw;
  logic [ADDR_W-1:0] fmask;

  always_comb begin
    sh = int'(idx_bits_i) * (4 - int'(lvl_i));
    mw = int'(idx_bits_i) + 3;
    fmask = (mw >= ADDR_W) ? '1 : ((64'd1 << mw) - 64'd1);
    addr_o = (tbl_i | ((va_i >> sh) & fmask)) & ~64'h7;
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [IDX_W-1:0]  idx_bits_i,
  output desc_kind_e        kind_o,
  output logic [ADDR_W-1:0] next_tbl_o,
  output logic [ADDR_W-1:0] leaf_addr_o,
  output logic [ADDR_W-1:0] page_size_o
);
  int psh;
  logic last_lvl;

  always_comb begin
    last_lvl = (lvl_i == LVL_W'(MAX_LVL));
    if (!desc_i[0] || (!desc_i[1] && last_lvl)) kind_o = DK_INVALID;
    else if (desc_i[1] && !last_lvl)             kind_o = DK_TABLE;
    else                                         kind_o = DK_LEAF;
    next_tbl_o = desc_i & OA_MASK;
    psh = int'(idx_bits_i) * (4 - int'(lvl_i)) + 3;
    page_size_o = (psh >= ADDR_W) ? '0 : (64'd1 << psh);
    leaf_addr_o = next_tbl_o | (va_i & (page_size_o - 64'd1));
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int TSZ_W = 6,
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       va_i,
  input  logic [63:0]       ttb_i,
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic [IDX_W-1:0]  idx_bits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic [63:0]       out_addr_o,
  output logic [63:0]       page_size_o,
  output logic [7:0]        fault_o
);
  walk_state_e state_q;
  logic [ADDR_W-1:0] va_q, tbl_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [IDX_W-1:0]  idx_q;

  logic [LVL_W-1:0]  start_lvl;
  logic [ADDR_W-1:0] start_base, next_tbl, leaf_addr, leaf_size;
  desc_kind_e        kind;

  ptw_start_calc #(.TSZ_W(TSZ_W), .IDX_W(IDX_W)) start_calc_i (
    .ttb_i(ttb_i), .tsz_i(tsz_i), .idx_bits_i(idx_bits_i),
    .lvl_o(start_lvl), .base_o(start_base)
  );

  ptw_desc_addr #(.IDX_W(IDX_W)) desc_addr_i (
    .tbl_i(tbl_q), .va_i(va_q), .lvl_i(lvl_q), .idx_bits_i(idx_q),
    .addr_o(mem_addr_o)
  );

  ptw_desc_decode #(.IDX_W(IDX_W)) desc_decode_i (
    .desc_i(mem_rsp_data_i), .va_i(va_q), .lvl_i(lvl_q), .idx_bits_i(idx_q),
    .kind_o(kind), .next_tbl_o(next_tbl), .leaf_addr_o(leaf_addr),
    .page_size_o(leaf_size)
  );

  assign mem_req_o = (state_q == ST_ISSUE);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      tbl_q       <= '0;
      lvl_q       <= '0;
      idx_q       <= '0;
      done_o      <= 1'b0;
      out_addr_o  <= '0;
      page_size_o <= '0;
      fault_o     <= FLT_NONE;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= va_i;
          tbl_q   <= start_base;
          lvl_q   <= start_lvl;
          idx_q   <= idx_bits_i;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            fault_o     <= FLT_WALK_ABORT;
            out_addr_o  <= '0;
            page_size_o <= '0;
            done_o      <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            unique case (kind)
              DK_TABLE: begin
                tbl_q   <= next_tbl;
                lvl_q   <= lvl_q + 1'b1;
                state_q <= ST_ISSUE;
              end
              DK_LEAF: begin
                fault_o     <= FLT_NONE;
                out_addr_o  <= leaf_addr;
                page_size_o <= leaf_size;
                done_o      <= 1'b1;
                state_q     <= ST_IDLE;
              end
              default: begin
                fault_o     <= FLT_XLATE;
                out_addr_o  <= '0;
                page_size_o <= '0;
                done_o      <= 1'b1;
                state_q     <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R3
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(out_addr_o) && $stable(fault_o) && $stable(page_size_o)));
  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  // R10
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == FLT_NONE || fault_o == FLT_WALK_ABORT || fault_o == FLT_XLATE));
  // R4
  abort_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_rsp_valid_i && mem_rsp_err_i) |=> (done_o && fault_o == FLT_WALK_ABORT));
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [63:0] va;
    logic [63:0] ttb;
    logic [5:0]  tsz;
    logic [7:0]  fault;
    logic [63:0] pa;
    logic [63:0] size;
    logic [3:0]  reads;
  } vec_t;

  localparam logic [63:0] VA_A = 64'h0000_0000_1234_5ABC;
  localparam logic [63:0] VA_B = 64'h0000_0000_0765_4321;
  localparam logic [63:0] VA_C = 64'h0000_0000_2222_2000;
  localparam logic [63:0] VA_E = 64'h0000_0000_3333_3456;
  localparam logic [63:0] VA_D = 64'h0000_0000_1555_5008;
  localparam logic [63:0] VA_F = 64'h0000_00AB_CDEF_1FFF;

  localparam vec_t VECS [NVEC] = '{
    '{VA_A, 64'h1000, 6'd25, 8'h00, 64'h0ABC_DABC, 64'h1000,   4'd3}, // R7 page at level 3
    '{VA_B, 64'h10000, 6'd25, 8'h00, 64'h4005_4321, 64'h20_0000, 4'd2}, // R7 block at level 2
    '{VA_C, 64'h20000, 6'd25, 8'h10, 64'h0, 64'h0, 4'd1},          // R5 invalid level 1
    '{VA_E, 64'h30000, 6'd25, 8'h10, 64'h0, 64'h0, 4'd3},          // R5 bit1 clear at level 3
    '{VA_D, 64'h40000, 6'd25, 8'h01, 64'h0, 64'h0, 4'd2},          // R4 error on 2nd read
    '{VA_F, 64'hFFFF_0000_0005_0ABC, 6'd16, 8'h00, 64'h6000_0FFF, 64'h1000, 4'd4} // R1 R2 level 0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] va = '0, ttb = '0;
  logic [5:0]  tsz = '0;
  logic [3:0]  idxb = 4'd9;
  logic busy, done, req, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [63:0] addr, rsp_data = '0, out_addr, page_size;
  logic [7:0]  fault;

  int checks = 0, fails = 0, reads = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF8;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va), .ttb_i(ttb),
    .tsz_i(tsz), .idx_bits_i(idxb), .busy_o(busy), .done_o(done),
    .mem_req_o(req), .mem_addr_o(addr), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_data_i(rsp_data), .mem_rsp_err_i(rsp_err),
    .out_addr_o(out_addr), .page_size_o(page_size), .fault_o(fault)
  );

  // behavioural table memory, one cycle latency
  always @(posedge clk) begin
    rsp_valid <= req;
    rsp_err   <= req && (addr == err_addr);
    rsp_data  <= (req && mem.exists(addr)) ? mem[addr] : 64'h0;
    if (req) reads <= reads + 1;
  end

  // R3 descriptor address formula with 9 index bits
  function automatic logic [63:0] daddr(logic [63:0] tbl, logic [63:0] v, int lvl);
    return (tbl | ((v >> (9 * (4 - lvl))) & 64'hFFF)) & ~64'h7;
  endfunction

  task automatic chk(input bit ok, input string req_id, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  // returns 1 when done seen; sampled at negedge
  task automatic run(input vec_t v, input bit poke_busy, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    va = v.va; ttb = v.ttb; tsz = v.tsz; start = 1'b1; reads = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", {63'd0, busy}, 64'd1);
    if (poke_busy) begin
      @(negedge clk);
      va = VA_B; ttb = 64'h10000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "R8 watchdog", 64'd0, 64'd1);
  endtask

  initial begin
    bit seen;
    logic [63:0] hold_pa;
    // table contents
    mem[daddr(64'h1000, VA_A, 1)] = 64'h2003;
    mem[daddr(64'h2000, VA_A, 2)] = 64'h3003;
    mem[daddr(64'h3000, VA_A, 3)] = 64'h0ABC_D003;
    mem[daddr(64'h10000, VA_B, 1)] = 64'h11003;
    mem[daddr(64'h11000, VA_B, 2)] = 64'h4000_0001;
    mem[daddr(64'h30000, VA_E, 1)] = 64'h31003;
    mem[daddr(64'h31000, VA_E, 2)] = 64'h32003;
    mem[daddr(64'h32000, VA_E, 3)] = 64'h5001;
    mem[daddr(64'h40000, VA_D, 1)] = 64'h41003;
    err_addr = daddr(64'h41000, VA_D, 2);
    mem[daddr(64'h50000, VA_F, 0)] = 64'h51003;
    mem[daddr(64'h51000, VA_F, 1)] = 64'h52003;
    mem[daddr(64'h52000, VA_F, 2)] = 64'h53003;
    mem[daddr(64'h53000, VA_F, 3)] = 64'h6000_0003;

    repeat (3) @(negedge clk);
    // reset state R8 R10
    chk(!busy && !done && !req, "R8 reset idle", {61'd0, busy, done, req}, 64'd0);
    chk(fault == 8'h00, "R10 reset fault", {56'd0, fault}, 64'd0);
    rst_n = 1'b1;

    for (int n = 0; n < NVEC; n++) begin
      run(VECS[n], 1'b0, seen);
      if (seen) begin
        chk(fault == VECS[n].fault, "R4 R5 R10 fault code", {56'd0, fault}, {56'd0, VECS[n].fault});
        chk(reads == int'(VECS[n].reads), "R1 R3 R6 read count", 64'(reads), 64'(VECS[n].reads));
        if (VECS[n].fault == 8'h00) begin
          chk(out_addr == VECS[n].pa, "R2 R7 output address", out_addr, VECS[n].pa);
          chk(page_size == VECS[n].size, "R7 page size", page_size, VECS[n].size);
        end
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle", {62'd0, done, busy}, 64'd0);
      end
    end

    // R9 outputs hold while idle
    hold_pa = out_addr;
    repeat (10) @(negedge clk);
    chk(out_addr == hold_pa, "R9 output hold", out_addr, hold_pa);

    // R9 start while busy ignored: walk A with B inputs poked mid-walk
    run(VECS[0], 1'b1, seen);
    if (seen) begin
      chk(out_addr == VECS[0].pa, "R9 busy start ignored addr", out_addr, VECS[0].pa);
      chk(reads == 3, "R9 busy start ignored reads", 64'(reads), 64'd3);
    end
    @(negedge clk);
    chk(!busy, "R9 no restart after poke", {63'd0, busy}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule